// File: doc/BRIEF.md
# Flash Command Window Register File

This block is the register window on the device side of a flash part. A host uses it to learn what device it is talking to, to stage an operation and to read how that operation ended. Access is through a simple synchronous word bus addressed by byte offset. A read returns data combinationally in the same cycle as the read strobe. A write takes effect at the next clock edge.

The host fills in a command code, a 32-bit target address, a 32-bit count and one data word. It then fires the operation by writing the value one to a dedicated trigger register. Two more one-shot triggers, also fired only by the value one, empty the program buffer and request a program/erase suspend. A simplified operation engine sits outside the block. It reports busy, the two suspend states and device availability as levels, and it reports error events as a one-cycle pulse vector.

The 16-bit status word combines two kinds of bit. Live read-only bits follow the engine's inputs. Sticky error bits are latched and then cleared by the act of reading the status word. Among the sticky bits is a 2-bit encoded region-program fault.

Top module: `fcw_regfile`

## Requirements
- R1: Reads at byte offsets 0x00, 0x02, 0x04 and 0x06 return the ASCII codes 0x0050, 0x0046, 0x004F and 0x0057. Offset 0x20 returns the MFR_ID parameter, 0x22 returns DEV_ID, 0x40 returns PBUF_OFS and 0x42 returns PBUF_WORDS.
- R2: The command registers are read/write and read back what was written:
  - code at 0x80
  - data at 0x84
  - address low/high halves at 0x88/0x8A
  - count low/high halves at 0x90/0x92

  The outputs `op_addr` and `op_count` show {high,low} and `op_data` shows the data register.
- R3: Writing 0x0001 to offset 0xC0 while `eng_busy` is low, with an accepted command code held, raises `op_start` for exactly the one cycle after the write. The accepted codes are 0x41, 0xE9, 0x20, 0x61, 0x62, 0x65, 0x98, 0x97, 0xC0 and 0xD0, and `op_code` shows the held code.
- R4: An execute write of 0x0001 while idle with any other code gives no `op_start` and sets status bit 4 (program error).
- R5: An execute write while `eng_busy` is high is ignored: no `op_start` and no status error.
- R6: A write of any value other than 0x0001 to 0xC0, 0xC4 or 0xC8 has no effect on `op_start`, `buf_clear` or `susp_req`.
- R7: Writing 0x0001 to 0xC4 pulses `buf_clear`, and writing 0x0001 to 0xC8 pulses `susp_req`. Each pulse lasts exactly the one cycle after the write.
- R8: The status word at 0xCC carries live read-only bits: bit2 = `eng_prog_susp`, bit6 = `eng_erase_susp`, bit7 = not `eng_busy` (ready), bit15 = `dev_avail`. Reading the status word never changes them.
- R9: Status bits 1, 3, 4, 5 and 12 and the field 9:8 (mask 0x133A) are sticky. They are set from `eng_err_set` and hold until the status word is read. That read returns them and clears them at the clock edge ending the read, but a set arriving in that same cycle wins. A nonzero region code in `eng_err_set[9:8]` replaces the field: 01 means a reprogram into object-mode data, 10 an object-mode program into control-mode data, 11 an invalid-half word program.
- R10: Reads of unmapped offsets (including odd offsets) and of the three trigger offsets return zero. Writes to unmapped offsets change no register and fire no pulse.
- R11: After reset the command registers read zero, no sticky status bit is set and no pulse output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset into the window |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid while bus_rd is high |
| eng_busy | input | 1 | Engine busy level |
| eng_prog_susp | input | 1 | Program suspended level |
| eng_erase_susp | input | 1 | Erase suspended level |
| dev_avail | input | 1 | Device available level |
| eng_err_set | input | 16 | One-cycle error event vector, status bit positions |
| op_start | output | 1 | One-cycle operation start pulse |
| op_code | output | 8 | Command code of the operation |
| op_addr | output | 32 | Target address |
| op_count | output | 32 | Data count |
| op_data | output | 16 | Command data word |
| buf_clear | output | 1 | One-cycle program buffer clear pulse |
| susp_req | output | 1 | One-cycle suspend request pulse |

## Verification
The bench overrides all four identity parameters with values other than the defaults: MFR_ID=0x1C2D, DEV_ID=0x7E01, PBUF_OFS=0x0200, PBUF_WORDS=64. A read mux that ignored the parameters would therefore be caught. The 8-bit offset width keeps the whole address space reachable, so random traffic lands on every mapped register, on odd offsets and on the gaps. Directed cases cover:
- every accepted command code
- same-cycle set against clear in the status word
- replacement of the region field

// File: rtl/fcw_pkg.sv
package fcw_pkg;

    localparam int WORD_W = 16;

    localparam logic [7:0] OFS_SIG_P   = 8'h00;
    localparam logic [7:0] OFS_SIG_F   = 8'h02;
    localparam logic [7:0] OFS_SIG_O   = 8'h04;
    localparam logic [7:0] OFS_SIG_W   = 8'h06;
    localparam logic [7:0] OFS_MFR     = 8'h20;
    localparam logic [7:0] OFS_DEV     = 8'h22;
    localparam logic [7:0] OFS_PB_OFS  = 8'h40;
    localparam logic [7:0] OFS_PB_SIZE = 8'h42;
    localparam logic [7:0] OFS_CODE    = 8'h80;
    localparam logic [7:0] OFS_DATA    = 8'h84;
    localparam logic [7:0] OFS_ADDR_LO = 8'h88;
    localparam logic [7:0] OFS_ADDR_HI = 8'h8A;
    localparam logic [7:0] OFS_CNT_LO  = 8'h90;
    localparam logic [7:0] OFS_CNT_HI  = 8'h92;
    localparam logic [7:0] OFS_EXEC    = 8'hC0;
    localparam logic [7:0] OFS_CLRBUF  = 8'hC4;
    localparam logic [7:0] OFS_SUSP    = 8'hC8;
    localparam logic [7:0] OFS_STATUS  = 8'hCC;

    localparam logic [WORD_W-1:0] TRIG_VAL    = 16'h0001;
    localparam logic [WORD_W-1:0] STICKY_MASK = 16'h133A;

    localparam int BIT_PSUSP = 2;
    localparam int BIT_PERR  = 4;
    localparam int BIT_ESUSP = 6;
    localparam int BIT_READY = 7;
    localparam int BIT_AVAIL = 15;
    localparam int REGION_LO = 8;

    typedef struct packed {
        logic [WORD_W-1:0] code;
        logic [WORD_W-1:0] data;
        logic [WORD_W-1:0] addr_lo;
        logic [WORD_W-1:0] addr_hi;
        logic [WORD_W-1:0] cnt_lo;
        logic [WORD_W-1:0] cnt_hi;
        logic              start;
        logic              clr;
        logic              susp;
    } win_state_t;

endpackage

// File: rtl/fcw_cmd_check.sv
module fcw_cmd_check
    import fcw_pkg::*;
(
    input  logic [WORD_W-1:0] code,
    output logic              known
);
    always_comb begin
        unique case (code)
            16'h0041, 16'h00E9, 16'h0020, 16'h0061, 16'h0062,
            16'h0065, 16'h0098, 16'h0097, 16'h00C0, 16'h00D0: known = 1'b1;
            default:                                         known = 1'b0;
        endcase
    end
endmodule

// File: rtl/fcw_status_reg.sv
module fcw_status_reg
    import fcw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] set_vec,
    input  logic              rd_clear,
    output logic [WORD_W-1:0] sticky_q
);
    localparam logic [WORD_W-1:0] FLAG_MASK = STICKY_MASK & ~(16'h3 << REGION_LO);

    logic [WORD_W-1:0] sticky_d;
    logic [1:0]        region_d;

    always_comb begin
        if (set_vec[REGION_LO +: 2] != 2'b00) begin
            region_d = set_vec[REGION_LO +: 2];
        end else if (rd_clear) begin
            region_d = 2'b00;
        end else begin
            region_d = sticky_q[REGION_LO +: 2];
        end
        sticky_d = ((rd_clear ? '0 : sticky_q) | set_vec) & FLAG_MASK;
        sticky_d[REGION_LO +: 2] = region_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sticky_q <= '0;
        end else begin
            sticky_q <= sticky_d;
        end
    end
endmodule

// File: rtl/fcw_read_mux.sv
module fcw_read_mux
    import fcw_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter logic [WORD_W-1:0] MFR_ID     = 16'h00A5,
    parameter logic [WORD_W-1:0] DEV_ID     = 16'h3C17,
    parameter logic [WORD_W-1:0] PBUF_OFS   = 16'h0400,
    parameter logic [WORD_W-1:0] PBUF_WORDS = 16'd32
) (
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  win_state_t        st,
    input  logic [WORD_W-1:0] status_word,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] sel;

    always_comb begin
        sel = '0;
        if (addr == ADDR_W'(OFS_SIG_P))   sel = 16'h0050;
        if (addr == ADDR_W'(OFS_SIG_F))   sel = 16'h0046;
        if (addr == ADDR_W'(OFS_SIG_O))   sel = 16'h004F;
        if (addr == ADDR_W'(OFS_SIG_W))   sel = 16'h0057;
        if (addr == ADDR_W'(OFS_MFR))     sel = MFR_ID;
        if (addr == ADDR_W'(OFS_DEV))     sel = DEV_ID;
        if (addr == ADDR_W'(OFS_PB_OFS))  sel = PBUF_OFS;
        if (addr == ADDR_W'(OFS_PB_SIZE)) sel = PBUF_WORDS;
        if (addr == ADDR_W'(OFS_CODE))    sel = st.code;
        if (addr == ADDR_W'(OFS_DATA))    sel = st.data;
        if (addr == ADDR_W'(OFS_ADDR_LO)) sel = st.addr_lo;
        if (addr == ADDR_W'(OFS_ADDR_HI)) sel = st.addr_hi;
        if (addr == ADDR_W'(OFS_CNT_LO))  sel = st.cnt_lo;
        if (addr == ADDR_W'(OFS_CNT_HI))  sel = st.cnt_hi;
        if (addr == ADDR_W'(OFS_STATUS))  sel = status_word;
        rdata = rd_en ? sel : '0;
    end
endmodule

// File: rtl/fcw_regfile.sv
module fcw_regfile
    import fcw_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter logic [WORD_W-1:0] MFR_ID     = 16'h00A5,
    parameter logic [WORD_W-1:0] DEV_ID     = 16'h3C17,
    parameter logic [WORD_W-1:0] PBUF_OFS   = 16'h0400,
    parameter logic [WORD_W-1:0] PBUF_WORDS = 16'd32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [WORD_W-1:0]   bus_wdata,
    output logic [WORD_W-1:0]   bus_rdata,
    input  logic                eng_busy,
    input  logic                eng_prog_susp,
    input  logic                eng_erase_susp,
    input  logic                dev_avail,
    input  logic [WORD_W-1:0]   eng_err_set,
    output logic                op_start,
    output logic [7:0]          op_code,
    output logic [2*WORD_W-1:0] op_addr,
    output logic [2*WORD_W-1:0] op_count,
    output logic [WORD_W-1:0]   op_data,
    output logic                buf_clear,
    output logic                susp_req
);
    win_state_t        st_d, st_q;
    logic              code_known;
    logic              exec_hit, run_ok, run_bad;
    logic              status_rd;
    logic [WORD_W-1:0] set_vec;
    logic [WORD_W-1:0] rc_q;
    logic [WORD_W-1:0] status_word;

    function automatic logic wr_at(input logic [7:0] ofs);
        return bus_wr && (bus_addr == ADDR_W'(ofs));
    endfunction

    fcw_cmd_check u_cmd_check (
        .code  (st_q.code),
        .known (code_known)
    );

    always_comb begin
        exec_hit  = wr_at(OFS_EXEC) && (bus_wdata == TRIG_VAL) && !eng_busy;
        run_ok    = exec_hit && code_known;
        run_bad   = exec_hit && !code_known;
        status_rd = bus_rd && (bus_addr == ADDR_W'(OFS_STATUS));
        set_vec   = (eng_err_set & STICKY_MASK)
                  | (run_bad ? (WORD_W'(1) << BIT_PERR) : '0);
    end

    always_comb begin
        st_d       = st_q;
        st_d.start = run_ok;
        st_d.clr   = wr_at(OFS_CLRBUF) && (bus_wdata == TRIG_VAL);
        st_d.susp  = wr_at(OFS_SUSP) && (bus_wdata == TRIG_VAL);
        if (wr_at(OFS_CODE))    st_d.code    = bus_wdata;
        if (wr_at(OFS_DATA))    st_d.data    = bus_wdata;
        if (wr_at(OFS_ADDR_LO)) st_d.addr_lo = bus_wdata;
        if (wr_at(OFS_ADDR_HI)) st_d.addr_hi = bus_wdata;
        if (wr_at(OFS_CNT_LO))  st_d.cnt_lo  = bus_wdata;
        if (wr_at(OFS_CNT_HI))  st_d.cnt_hi  = bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    fcw_status_reg u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .rd_clear (status_rd),
        .sticky_q (rc_q)
    );

    always_comb begin
        status_word            = rc_q;
        status_word[BIT_PSUSP] = eng_prog_susp;
        status_word[BIT_ESUSP] = eng_erase_susp;
        status_word[BIT_READY] = !eng_busy;
        status_word[BIT_AVAIL] = dev_avail;
    end

    fcw_read_mux #(
        .ADDR_W     (ADDR_W),
        .MFR_ID     (MFR_ID),
        .DEV_ID     (DEV_ID),
        .PBUF_OFS   (PBUF_OFS),
        .PBUF_WORDS (PBUF_WORDS)
    ) u_rd_mux (
        .rd_en       (bus_rd),
        .addr        (bus_addr),
        .st          (st_q),
        .status_word (status_word),
        .rdata       (bus_rdata)
    );

    assign op_start  = st_q.start;
    assign op_code   = st_q.code[7:0];
    assign op_addr   = {st_q.addr_hi, st_q.addr_lo};
    assign op_count  = {st_q.cnt_hi, st_q.cnt_lo};
    assign op_data   = st_q.data;
    assign buf_clear = st_q.clr;
    assign susp_req  = st_q.susp;
endmodule

// File: rtl/fcw_regfile_chk.sv
module fcw_regfile_chk
    import fcw_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [WORD_W-1:0] bus_wdata,
    input logic [WORD_W-1:0] bus_rdata,
    input logic              eng_busy,
    input logic              dev_avail,
    input logic [WORD_W-1:0] eng_err_set,
    input logic              op_start,
    input logic              buf_clear,
    input logic              susp_req,
    input logic [WORD_W-1:0] rc_q
);
    localparam logic [WORD_W-1:0] FLAG_ONLY = 16'h103A;

    logic at_exec, at_clr, at_susp, at_stat;
    assign at_exec = bus_addr == ADDR_W'(OFS_EXEC);
    assign at_clr  = bus_addr == ADDR_W'(OFS_CLRBUF);
    assign at_susp = bus_addr == ADDR_W'(OFS_SUSP);
    assign at_stat = bus_addr == ADDR_W'(OFS_STATUS);

    p_start_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |-> $past(bus_wr && at_exec && bus_wdata == TRIG_VAL && !eng_busy));

    p_busy_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && at_exec && eng_busy) |=> !op_start);

    p_bad_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (at_exec || at_clr || at_susp) && bus_wdata != TRIG_VAL)
        |=> !(op_start || buf_clear || susp_req));

    p_clear_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        buf_clear |-> $past(bus_wr && at_clr && bus_wdata == TRIG_VAL));

    p_susp_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        susp_req |-> $past(bus_wr && at_susp && bus_wdata == TRIG_VAL));

    p_live_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && at_stat) |-> (bus_rdata[BIT_READY] == !eng_busy
                                 && bus_rdata[BIT_AVAIL] == dev_avail));

    p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && at_stat && !bus_wr && eng_err_set == '0) |=> rc_q == '0);

    p_sticky_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && at_stat) |=> ((rc_q & $past(rc_q) & FLAG_ONLY) == ($past(rc_q) & FLAG_ONLY)));

    p_odd_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr[0]) |-> bus_rdata == '0);
endmodule

bind fcw_regfile fcw_regfile_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .eng_busy    (eng_busy),
    .dev_avail   (dev_avail),
    .eng_err_set (eng_err_set),
    .op_start    (op_start),
    .buf_clear   (buf_clear),
    .susp_req    (susp_req),
    .rc_q        (rc_q)
);

// File: tb/tb_fcw_regfile.sv
module tb_fcw_regfile;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] P_MFR = 16'h1C2D;
    localparam logic [15:0] P_DEV = 16'h7E01;
    localparam logic [15:0] P_PBO = 16'h0200;
    localparam logic [15:0] P_PBW = 16'd64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        eng_busy = 1'b0, eng_prog_susp = 1'b0, eng_erase_susp = 1'b0;
    logic        dev_avail = 1'b1;
    logic [15:0] eng_err_set = '0;
    logic        op_start, buf_clear, susp_req;
    logic [7:0]  op_code;
    logic [31:0] op_addr, op_count;
    logic [15:0] op_data;

    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;
    logic seen_start, seen_clr, seen_susp;
    logic [15:0] rd_val;
    logic [15:0] m_code = '0, m_data = '0, m_al = '0, m_ah = '0, m_cl = '0, m_ch = '0;
    logic [15:0] m_rc = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fcw_regfile #(.ADDR_W(8), .MFR_ID(P_MFR), .DEV_ID(P_DEV),
                  .PBUF_OFS(P_PBO), .PBUF_WORDS(P_PBW)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_busy(eng_busy), .eng_prog_susp(eng_prog_susp),
        .eng_erase_susp(eng_erase_susp), .dev_avail(dev_avail),
        .eng_err_set(eng_err_set), .op_start(op_start), .op_code(op_code),
        .op_addr(op_addr), .op_count(op_count), .op_data(op_data),
        .buf_clear(buf_clear), .susp_req(susp_req));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic known_code(input logic [15:0] c);
        return c inside {16'h41, 16'hE9, 16'h20, 16'h61, 16'h62,
                         16'h65, 16'h98, 16'h97, 16'hC0, 16'hD0};
    endfunction

    function automatic logic [15:0] live_bits();
        return {dev_avail, 7'b0, !eng_busy, eng_erase_susp, 3'b0, eng_prog_susp, 2'b0};
    endfunction

    function automatic logic [15:0] exp_rd(input logic [7:0] a);
        case (a)
            8'h00: return 16'h0050;
            8'h02: return 16'h0046;
            8'h04: return 16'h004F;
            8'h06: return 16'h0057;
            8'h20: return P_MFR;
            8'h22: return P_DEV;
            8'h40: return P_PBO;
            8'h42: return P_PBW;
            8'h80: return m_code;
            8'h84: return m_data;
            8'h88: return m_al;
            8'h8A: return m_ah;
            8'h90: return m_cl;
            8'h92: return m_ch;
            8'hCC: return m_rc | live_bits();
            default: return 16'h0000;
        endcase
    endfunction

    task automatic model_wr(input logic [7:0] a, input logic [15:0] d);
        case (a)
            8'h80: m_code = d;
            8'h84: m_data = d;
            8'h88: m_al = d;
            8'h8A: m_ah = d;
            8'h90: m_cl = d;
            8'h92: m_ch = d;
            default: ;
        endcase
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        seen_start = op_start; seen_clr = buf_clear; seen_susp = susp_req;
        model_wr(a, d);
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
        if (a == 8'hCC) m_rc = '0;
    endtask

    task automatic err_pulse(input logic [15:0] v);
        @(negedge clk);
        eng_err_set = v;
        @(negedge clk);
        eng_err_set = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 op_start", op_start, 0);
        chk("R11 buf_clear", buf_clear, 0);
        chk("R11 susp_req", susp_req, 0);
        bus_read(8'h80, rd_val); chk("R11 code reg", rd_val, 0);
        bus_read(8'hCC, rd_val); chk("R11 status", rd_val, 16'h8080);

        // R1 identity
        foreach (exp_rd_list[i]) begin
            bus_read(exp_rd_list[i], rd_val);
            chk("R1 identity", rd_val, exp_rd(exp_rd_list[i]));
        end

        // R2 command registers
        bus_write(8'h80, 16'h0041);
        bus_write(8'h84, 16'hBEEF);
        bus_write(8'h88, 16'h1234);
        bus_write(8'h8A, 16'h0056);
        bus_write(8'h90, 16'h0010);
        bus_write(8'h92, 16'h0002);
        chk("R2 op_addr", op_addr, 32'h0056_1234);
        chk("R2 op_count", op_count, 32'h0002_0010);
        chk("R2 op_data", op_data, 16'hBEEF);
        for (int i = 0; i < 6; i++) begin
            logic [7:0] a;
            a = (i < 4) ? 8'(8'h80 + 4 * (i / 2) * 2 + 2 * (i % 2) * (i / 2)) : 8'(8'h90 + 2 * (i - 4));
            bus_read(a, rd_val);
            chk("R2 readback", rd_val, exp_rd(a));
        end

        // R3 start
        bus_write(8'hC0, 16'h0001);
        chk("R3 start pulse", seen_start, 1);
        chk("R3 op_code", op_code, 8'h41);
        @(negedge clk);
        chk("R3 single cycle", op_start, 0);

        // R6 wrong trigger values
        bus_write(8'hC0, 16'h0003); chk("R6 exec ignored", seen_start, 0);
        bus_write(8'hC4, 16'h0002); chk("R6 clr ignored", seen_clr, 0);
        bus_write(8'hC8, 16'h0000); chk("R6 susp ignored", seen_susp, 0);
        bus_write(8'hC0, 16'h0101); chk("R6 exec ignored 2", seen_start, 0);

        // R7 triggers
        bus_write(8'hC4, 16'h0001); chk("R7 buf_clear", seen_clr, 1);
        chk("R7 no start", seen_start, 0);
        @(negedge clk); chk("R7 clr single", buf_clear, 0);
        bus_write(8'hC8, 16'h0001); chk("R7 susp_req", seen_susp, 1);

        // R4 unknown code
        bus_write(8'h80, 16'h0055);
        bus_write(8'hC0, 16'h0001); chk("R4 no start", seen_start, 0);
        m_rc = 16'h0010;
        bus_read(8'hCC, rd_val); chk("R4 perr set", rd_val, 16'h8090);
        bus_read(8'hCC, rd_val); chk("R9 cleared after read", rd_val, 16'h8080);

        // R5 busy
        eng_busy = 1'b1;
        bus_write(8'h80, 16'h0020);
        bus_write(8'hC0, 16'h0001); chk("R5 no start busy", seen_start, 0);
        bus_read(8'hCC, rd_val); chk("R5 no error busy", rd_val, 16'h8000);
        eng_busy = 1'b0;

        // R3 every accepted code
        foreach (code_list[i]) begin
            bus_write(8'h80, code_list[i]);
            bus_write(8'hC0, 16'h0001);
            chk("R3 accepted code start", seen_start, 1);
            chk("R3 accepted op_code", op_code, code_list[i][7:0]);
        end

        // R8 read-only bits
        eng_prog_susp = 1'b1; eng_erase_susp = 1'b1; dev_avail = 1'b0;
        bus_read(8'hCC, rd_val); chk("R8 live bits", rd_val, 16'h00C4);
        bus_read(8'hCC, rd_val); chk("R8 not cleared", rd_val, 16'h00C4);
        eng_prog_susp = 1'b0; eng_erase_susp = 1'b0; dev_avail = 1'b1;

        // R9 sticky bits
        err_pulse(16'hFFFF);
        bus_read(8'hCC, rd_val); chk("R9 all sticky", rd_val, 16'h93BA);
        bus_read(8'hCC, rd_val); chk("R9 cleared", rd_val, 16'h8080);
        err_pulse(16'h0100);
        err_pulse(16'h0200);
        bus_read(8'hCC, rd_val); chk("R9 region replaced", rd_val, 16'h8280);
        err_pulse(16'h0008);
        err_pulse(16'h0020);
        bus_read(8'hCC, rd_val); chk("R9 flags accumulate", rd_val, 16'h80A8);
        // R9 set wins over same-cycle clear
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 8'hCC; eng_err_set = 16'h0010;
        #1 rd_val = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0; eng_err_set = '0;
        chk("R9 read during set", rd_val, 16'h8080);
        bus_read(8'hCC, rd_val); chk("R9 set wins", rd_val, 16'h8090);

        // R10 unmapped
        bus_write(8'h30, 16'hFFFF);
        chk("R10 no pulse", {seen_start, seen_clr, seen_susp}, 0);
        bus_read(8'h30, rd_val); chk("R10 unmapped read", rd_val, 0);
        bus_read(8'h81, rd_val); chk("R10 odd read", rd_val, 0);
        bus_read(8'hC0, rd_val); chk("R10 trigger read", rd_val, 0);
        bus_read(8'h80, rd_val); chk("R10 code intact", rd_val, m_code);

        // random traffic
        void'($urandom(32'h5EED_0C0D));
        for (int n = 0; n < 400; n++) begin
            logic [7:0]  a;
            logic [15:0] d;
            a = 8'($urandom);
            d = 16'($urandom);
            if ($urandom % 3 == 0) a = 8'h80 + 8'(2 * ($urandom % 10));
            if (a inside {8'hC0, 8'hC4, 8'hC8}) d = d | 16'h8000;
            if ($urandom % 2 == 0) begin
                bus_write(a, d);
                chk("R10 random write no pulse", {seen_start, seen_clr, seen_susp}, 0);
            end else begin
                logic [15:0] e;
                e = exp_rd(a);
                bus_read(a, rd_val);
                chk("R2 random read", rd_val, e);
            end
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    logic [7:0]  exp_rd_list [8] = '{8'h00, 8'h02, 8'h04, 8'h06, 8'h20, 8'h22, 8'h40, 8'h42};
    logic [15:0] code_list [10] = '{16'h41, 16'hE9, 16'h20, 16'h61, 16'h62,
                                    16'h65, 16'h98, 16'h97, 16'hC0, 16'hD0};

    initial begin
        if (!known_code(16'h41)) $display("bench table broken");
    end
endmodule